// File: doc/BRIEF.md
# Bidirectional Walking-Light Driver with Confirmed Direction Toggle

This block lights one of four LEDs at a time and moves the lit position by one place on every step of an internal timer. The timer is built from a system-clock divider that makes an instruction-rate enable, a prescaler on that enable and a small overflow counter. The lit position travels toward bit 0 or toward the top bit. When it falls off one end, it re-enters at the other end.

A push button, active low and idle high, reverses the direction of travel. The raw button level goes through a two-flop synchronizer. A high-to-low transition starts a fixed settling wait, counted in instruction enables. When the wait ends, the synchronized level is sampled once more. The direction flips only if the button still reads low. Edges that arrive while a wait is running are not acted on. Each step tick and each confirmed press is a one-cycle event, so each is handled exactly once.

The divider, prescaler, counter width and settling wait are all parameters. A test environment can therefore shorten every interval.

Top module: `led_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `led` is 4'b1000 (only bit 3 lit) and `dir_left` is 0 (travel toward bit 0).
- R2: Exactly one bit of `led` is 1 at all times out of reset.
- R3: With `dir_left` = 0, each step moves the lit bit one place toward bit 0, and a lit bit 0 moves to bit 3.
- R4: With `dir_left` = 1, each step moves the lit bit one place toward bit 3, and a lit bit 3 moves to bit 0.
- R5: A step occurs once every INSN_DIV × PRESCALE × 2^TMR_W clocks. The first step after reset release is taken on the INSN_DIV × PRESCALE × 2^TMR_W-th rising edge.
- R6: A 1-to-0 transition on `sw_n` (0 = pressed) toggles `dir_left` after the two synchronizer stages and a wait of DB_WAIT instruction enables, provided the synchronized level is still 0 at the end of the wait.
- R7: A press that returns to 1 before the end of the wait leaves `dir_left` unchanged.
- R8: Transitions on `sw_n` during a running wait start no second wait, so one wait yields at most one toggle.
- R9: Holding `sw_n` at 0 for any length of time yields exactly one toggle; a new 1-to-0 transition is needed for another.
- R10: `led` changes only on step ticks. A direction change takes effect at the next step and does not move the lit bit by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| sw_n | input | 1 | Raw push-button level, 0 = pressed |
| led | output | 4 | LED drive bits, one-hot |
| dir_left | output | 1 | Travel direction, 1 = toward bit 3 |

## Verification
The bench drives a clean long press, a short bounce that ends before the wait expires, and a glitch followed by a long hold, so that a second edge lands inside a running wait. It also runs long enough for the pattern to wrap at both ends. A design that toggles on the raw edge would flip on the short bounce. A design that restarts the wait on every edge would toggle twice on the glitch-then-hold press. A left wrap that leaks into a fifth bit would go dark or light two LEDs. An off-by-one in the prescaler chain shows up as a first step on the wrong edge.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic {
    PF_IDLE = 1'b0,
    PF_WAIT = 1'b1
  } pf_state_t;

  function automatic logic [3:0] ring_step(input logic [3:0] cur, input logic toward_top);
    if (toward_top) ring_step = {cur[2:0], cur[3]};
    else            ring_step = {cur[0], cur[3:1]};
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int INSN_DIV = 4,
  parameter int PRESCALE = 256,
  parameter int TMR_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic insn_ce,
  output logic step_tick
);
  localparam int DIV_W = (INSN_DIV > 1) ? $clog2(INSN_DIV) : 1;
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSN_DIV - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             pre_tick;

  always_comb begin
    insn_ce   = (div_q == DIV_LAST);
    pre_tick  = insn_ce && (pre_q == PRE_LAST);
    step_tick = pre_tick && (&tmr_q);
    div_d     = insn_ce ? '0 : div_q + 1'b1;
    pre_d     = pre_q;
    if (insn_ce) pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    tmr_d     = pre_tick ? tmr_q + 1'b1 : tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/press_filter.sv
module press_filter
  import walker_pkg::*;
#(
  parameter int DB_WAIT = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_ce,
  input  logic sw_n,
  output logic sw_lvl,
  output logic flip
);
  localparam int CNT_W = $clog2(DB_WAIT + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DB_WAIT);

  logic              meta_q, sync_q, prev_q;
  pf_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              fall;

  assign sw_lvl = sync_q;

  always_comb begin
    fall  = prev_q && !sync_q;
    st_d  = st_q;
    cnt_d = cnt_q;
    flip  = 1'b0;
    case (st_q)
      PF_IDLE: if (fall) begin
        st_d  = PF_WAIT;
        cnt_d = LOAD;
      end
      PF_WAIT: if (insn_ce) begin
        if (cnt_q <= 1) begin
          st_d = PF_IDLE;
          flip = !sync_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= PF_IDLE;
      cnt_q  <= '0;
    end else begin
      meta_q <= sw_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/led_ring.sv
module led_ring
  import walker_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       flip,
  output logic [3:0] led,
  output logic       dir_left
);
  logic [3:0] led_d;
  logic       dir_d;

  always_comb begin
    led_d = step ? ring_step(led, dir_left) : led;
    dir_d = flip ? !dir_left : dir_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led      <= 4'b1000;
      dir_left <= 1'b0;
    end else begin
      led      <= led_d;
      dir_left <= dir_d;
    end
  end
endmodule

// File: rtl/led_walker.sv
module led_walker #(
  parameter int INSN_DIV = 4,
  parameter int PRESCALE = 256,
  parameter int TMR_W    = 8,
  parameter int DB_WAIT  = 625
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_n,
  output logic [3:0] led,
  output logic       dir_left
);
  logic insn_ce;
  logic step_tick;
  logic sw_lvl;
  logic flip;

  step_timer #(.INSN_DIV(INSN_DIV), .PRESCALE(PRESCALE), .TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .insn_ce(insn_ce), .step_tick(step_tick)
  );

  press_filter #(.DB_WAIT(DB_WAIT)) u_press (
    .clk(clk), .rst_n(rst_n), .insn_ce(insn_ce), .sw_n(sw_n),
    .sw_lvl(sw_lvl), .flip(flip)
  );

  led_ring u_ring (
    .clk(clk), .rst_n(rst_n), .step(step_tick), .flip(flip),
    .led(led), .dir_left(dir_left)
  );
endmodule

// File: rtl/led_walker_chk.sv
module led_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] led,
  input logic       dir_left,
  input logic       step_tick,
  input logic       sw_lvl
);
  a_r2_one_lit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(led) == 1);

  a_r3_right_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(led) && !$past(dir_left)) |-> led == {$past(led[0]), $past(led[3:1])});

  a_r4_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(led) && $past(dir_left)) |-> led == {$past(led[2:0]), $past(led[3])});

  a_r6_toggle_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_left) |-> !$past(sw_lvl));

  a_r8_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_left) |=> $stable(dir_left));

  a_r10_led_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> $past(step_tick));
endmodule

bind led_walker led_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .led(led), .dir_left(dir_left),
  .step_tick(step_tick), .sw_lvl(sw_lvl)
);

// File: tb/sim_led_walker.sv
module sim_led_walker;
  localparam int CLK_PERIOD = 10;
  localparam int INSN_DIV = 4;
  localparam int PRESCALE = 4;
  localparam int TMR_W    = 2;
  localparam int DB_WAIT  = 8;
  localparam int STEP_P   = INSN_DIV * PRESCALE * (1 << TMR_W);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_n = 1'b1;
  logic [3:0] led;
  logic       dir_left;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  led_walker #(.INSN_DIV(INSN_DIV), .PRESCALE(PRESCALE), .TMR_W(TMR_W), .DB_WAIT(DB_WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .led(led), .dir_left(dir_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int   k;
  int   m_led;
  bit   m_left;
  bit   m_wait;
  int   m_rem;
  bit   h[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k = 0; m_led = 3; m_left = 0; m_wait = 0; m_rem = 0;
      h = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit ce, tick;
      ce   = (k % INSN_DIV) == INSN_DIV - 1;
      tick = (k % STEP_P) == STEP_P - 1;
      if (tick) m_led = m_left ? (m_led + 1) % 4 : (m_led + 3) % 4;
      if (!m_wait) begin
        if (h[2] && !h[1]) begin m_wait = 1; m_rem = DB_WAIT; end
      end else if (ce) begin
        if (m_rem <= 1) begin
          m_wait = 0;
          if (!h[1]) m_left = !m_left;
        end else m_rem--;
      end
      h.pop_back();
      h.push_front(sw_n);
      k++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(led == 4'(1 << m_led), m_left ? "R4 led step" : "R3 led step", int'(led), 1 << m_led);
      check($countones(led) == 1, "R2 one lit", $countones(led), 1);
      check(dir_left == m_left, "R6 direction", int'(dir_left), int'(m_left));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input bit v, input int n);
    @(negedge clk); sw_n = v;
    idle(n - 1);
  endtask

  initial begin
    int n;
    bit d0;
    idle(3);
    check(led == 4'b1000, "R1 led in reset", int'(led), 8);
    check(dir_left == 1'b0, "R1 dir in reset", int'(dir_left), 0);
    rst_n = 1'b1;
    check(led == 4'b1000, "R1 led after release", int'(led), 8);
    n = 0;
    do begin @(negedge clk); n++; end while (led == 4'b1000 && n < 1000);
    check(n == STEP_P, "R5 first step edge", n, STEP_P);
    check(led == 4'b0100, "R3 first step", int'(led), 4);
    idle(3 * STEP_P);
    check(led == 4'b1000, "R3 right wrap", int'(led), 8);
    // long hold: one toggle
    drive(1'b0, 6 * DB_WAIT * INSN_DIV);
    check(dir_left == 1'b1, "R6 confirmed press", int'(dir_left), 1);
    check(led == 4'b1000 || led == 4'b0001 || led == 4'b0010 || led == 4'b0100, "R10 led valid", int'(led), 8);
    drive(1'b1, 20);
    check(dir_left == 1'b1, "R9 one toggle per hold", int'(dir_left), 1);
    idle(5 * STEP_P);
    // bounce shorter than the wait
    d0 = dir_left;
    drive(1'b0, 5);
    drive(1'b1, 3 * DB_WAIT * INSN_DIV);
    check(dir_left == d0, "R7 short bounce ignored", int'(dir_left), int'(d0));
    // glitch then hold: a second edge inside the wait
    drive(1'b0, 3);
    drive(1'b1, 3);
    drive(1'b0, 6 * DB_WAIT * INSN_DIV);
    check(dir_left == !d0, "R8 single toggle per wait", int'(dir_left), int'(!d0));
    drive(1'b1, 20);
    idle(5 * STEP_P);
    check(dir_left == 1'b0, "R6 back to right", int'(dir_left), 0);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule